// File: doc/BRIEF.md
# Instruction Loop Buffer

This block sits in the fetch stage between the instruction fetch unit and main memory. It holds one contiguous window of up to sixteen instruction words and looks up every fetch address in that window before any memory access is made. A fetch that falls inside the window is answered from the buffer. A fetch outside it goes to memory, and the buffer refills from that address.

While no demand fetch is waiting, the block fetches words ahead of the current fetch pointer, so straight-line code rarely waits for memory. A backward branch that closes a short loop lands inside the window. A short forward branch lands inside it as well. A loop that fits is therefore read from memory only on its first pass.

The window is circular, described by a base address and a word count. When all sixteen slots are in use, each new prefetched word replaces the oldest word behind the fetch pointer. The memory port allows one read in flight at a time, and that read may take any number of cycles.

Top module: `loop_fetch_buf`

## Requirements
- R1: After reset `fetch_valid` and `mem_req` are 0, `fetch_ready` is 1, and the window is empty, so the first fetch misses.
- R2: A fetch whose address A satisfies base <= A < base + count is answered with `fetch_hit` = 1 and the buffered word, with no memory read for it.
- R3: A fetch outside the window, and not equal to base + count, empties the window, moves the base to A, and reads A from memory. The response carries `fetch_hit` = 0 and the word returned by memory.
- R4: A fetch at exactly base + count is a miss that appends to the window without emptying it. Words already held still hit afterwards.
- R5: Prefetch reads base + count only while fewer than LOOKAHEAD (default 4) words lie beyond the fetch pointer. After a settled miss at A, exactly A..A+4 are read (5 reads), and the window ends at fetch pointer + 5.
- R6: The window never holds more than DEPTH (16) words. Appending to a full window discards the oldest word, and a later fetch of that word misses.
- R7: At most one memory read is outstanding. A prefetch still in flight when the window is emptied is discarded and never appended. Every response carries the word of the address fetched; the bench memory returns {~A, A} for address A.
- R8: A loop of at most DEPTH − LOOKAHEAD words makes no memory reads and hits on every fetch from its second pass onward.
- R9: `fetch_ready` is 0 from the cycle after a miss is accepted until its response appears, so no new fetch is taken meanwhile.
- R10: A hit response appears in the cycle right after the cycle in which the request was accepted, and `fetch_valid` is high for exactly one cycle per fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Fetch request, taken when `fetch_ready` is 1 |
| fetch_addr | input | AW | Word address to fetch |
| fetch_ready | output | 1 | Block can take a fetch this cycle |
| fetch_valid | output | 1 | One-cycle response strobe |
| fetch_data | output | DW | Fetched instruction word |
| fetch_hit | output | 1 | Response was served from the buffer |
| mem_req | output | 1 | One-cycle memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench targets a fetch at exactly the window's end, which should extend the window. A design that flushes there instead would then miss on the older words. It also aims at words just pushed out of a full window; a design that does not discard them would hit and return overwritten data. A third target is a far miss taken while a prefetch is in flight; a design that appends the stale prefetch would return the wrong word or hit on an address it never read. Finally, the bench counts memory reads: it checks the look-ahead depth after a miss, and checks that a fitting loop makes no reads on its second and third passes. A design with the wrong stop condition or a thrashing window fails those counts.

// File: rtl/loop_fetch_buf.sv
module loop_fetch_buf #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int LOOKAHEAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_ready,
  output logic          fetch_valid,
  output logic [DW-1:0] fetch_data,
  output logic          fetch_hit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] words [DEPTH];
  logic [AW-1:0] base, fptr;
  logic [CW-1:0] count;
  logic          busy, drop, dm_pend;

  logic [AW-1:0] cnt_w, off, foff, ahead, tail;
  logic          hit, extend, accept, pf_ok, land;

  assign cnt_w  = AW'(count);
  assign off    = fetch_addr - base;
  assign foff   = fptr - base;
  assign ahead  = cnt_w - foff - AW'(1);
  assign tail   = base + cnt_w;
  assign hit    = off < cnt_w;
  assign extend = off == cnt_w;
  assign land   = mem_rvalid && !drop;
  assign pf_ok  = (count != '0) && (ahead < AW'(LOOKAHEAD));

  assign fetch_ready = !dm_pend;
  assign accept      = fetch_req && fetch_ready;
  assign mem_req     = !busy && (dm_pend || pf_ok);
  assign mem_addr    = tail;

  always_ff @(posedge clk)
    if (land) words[tail[IW-1:0]] <= mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base        <= '0;
      fptr        <= '0;
      count       <= '0;
      busy        <= 1'b0;
      drop        <= 1'b0;
      dm_pend     <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_data  <= '0;
      fetch_hit   <= 1'b0;
    end else begin
      fetch_valid <= 1'b0;
      if (mem_req) busy <= 1'b1;
      if (mem_rvalid) begin
        busy <= 1'b0;
        if (drop) drop <= 1'b0;
        else begin
          if (count == CW'(DEPTH)) base <= base + AW'(1);
          else count <= count + CW'(1);
          if (dm_pend) begin
            dm_pend     <= 1'b0;
            fetch_valid <= 1'b1;
            fetch_data  <= mem_rdata;
            fetch_hit   <= 1'b0;
          end
        end
      end
      if (accept) begin
        fptr <= fetch_addr;
        if (hit) begin
          fetch_valid <= 1'b1;
          fetch_data  <= words[fetch_addr[IW-1:0]];
          fetch_hit   <= 1'b1;
        end else if (extend) begin
          if (land) begin
            fetch_valid <= 1'b1;
            fetch_data  <= mem_rdata;
            fetch_hit   <= 1'b0;
          end else dm_pend <= 1'b1;
        end else begin
          base    <= fetch_addr;
          count   <= '0;
          dm_pend <= 1'b1;
          drop    <= (busy && !mem_rvalid) || mem_req;
        end
      end
    end
  end

  // R7
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R6
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10
  hit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (fetch_valid && fetch_hit));

  // R3
  miss_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_hit) |-> $past(mem_rvalid));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && !(extend && land)) |=> !fetch_ready);
endmodule

// File: tb/loop_fetch_buf_tb.sv
`timescale 1ns/1ps
module loop_fetch_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ready, fetch_valid, fetch_hit;
  logic [31:0] fetch_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int rd_cnt;

  always #2.5 clk = ~clk;

  loop_fetch_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_hit(fetch_hit),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: latency varies 2..5 cycles, data {~A, A}
  int          lat_cnt;
  int          lat_sel;
  logic [15:0] pend_a;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; lat_cnt <= 0; lat_sel <= 0;
      pend_a <= '0; rd_cnt <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        pend_a  <= mem_addr;
        lat_cnt <= 2 + (lat_sel % 4);
        lat_sel <= lat_sel + 1;
        rd_cnt  <= rd_cnt + 1;
      end else if (lat_cnt > 0) begin
        if (lat_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= {~pend_a, pend_a};
        end
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, output logic [31:0] d,
                          output logic h, output int lat);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    lat = 1;
    while (!fetch_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    d = fetch_data; h = fetch_hit;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  localparam logic [15:0] VEC [20] = '{
    16'h0040, 16'h0041, 16'h0044, 16'h0043, 16'h0048,
    16'h004D, 16'h0041, 16'h0050, 16'h0055, 16'h0058,
    16'h0030, 16'h0030, 16'h0034, 16'h0039, 16'h0100,
    16'h0104, 16'h0108, 16'h010C, 16'h0100, 16'h0101
  };

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        h;
    int          lat, rd0;
    bit          mvalid;
    int          mbase, mend, start;
    string       tag;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(fetch_valid == 1'b0, "R1", "fetch_valid", 32'(fetch_valid), 0);
    check(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 0);
    check(fetch_ready == 1'b1, "R1", "fetch_ready", 32'(fetch_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_req == 1'b0, "R1", "no prefetch when empty", 32'(mem_req), 0);

    mvalid = 0; mbase = 0; mend = 0;
    foreach (VEC[i]) begin
      automatic int a = int'(VEC[i]);
      automatic bit exp_h;
      start = (mend - 16 > mbase) ? mend - 16 : mbase;
      exp_h = mvalid && a >= start && a < mend;
      if (exp_h) tag = "R2 R5";
      else if (mvalid && a == mend) tag = "R4";
      else if (mvalid && a >= mbase && a < start) tag = "R6";
      else tag = (mvalid ? "R3" : "R1 R3");
      do_fetch(VEC[i], d, h, lat);
      check(lat < 200, tag, "response timeout", 32'(lat), 0);
      check(h == exp_h, tag, "hit flag", 32'(h), 32'(exp_h));
      check(d == {~VEC[i], VEC[i]}, "R7", "data", d, {~VEC[i], VEC[i]});
      if (exp_h) check(lat == 1, "R10", "hit latency", 32'(lat), 1);
      if (exp_h) mend = (a + 5 > mend) ? a + 5 : mend;
      else if (mvalid && a == mend) mend = a + 5;
      else begin mbase = a; mend = a + 5; mvalid = 1; end
      settle();
    end

    // R9 and R5: miss stalls the port, then exactly five reads
    rd0 = rd_cnt;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 16'h0300;
    @(negedge clk);
    fetch_req = 1'b0;
    check(fetch_ready == 1'b0, "R9", "ready during miss", 32'(fetch_ready), 0);
    lat = 0;
    while (!fetch_valid && lat < 200) begin @(negedge clk); lat++; end
    check(fetch_data == {~16'h0300, 16'h0300}, "R3", "miss data", fetch_data,
          {~16'h0300, 16'h0300});
    @(negedge clk);
    check(fetch_valid == 1'b0, "R10", "single-cycle valid", 32'(fetch_valid), 0);
    settle();
    check(rd_cnt - rd0 == 5, "R5", "look-ahead reads", 32'(rd_cnt - rd0), 5);

    // R7: far miss while a prefetch is in flight
    do_fetch(16'h0700, d, h, lat);
    do_fetch(16'h0900, d, h, lat);
    check(d == {~16'h0900, 16'h0900}, "R7", "flush data", d, {~16'h0900, 16'h0900});
    check(h == 1'b0, "R7", "flush hit", 32'(h), 0);
    settle();
    do_fetch(16'h0701, d, h, lat);
    check(h == 1'b0, "R7", "stale prefetch dropped", 32'(h), 0);
    check(d == {~16'h0701, 16'h0701}, "R7", "stale data", d, {~16'h0701, 16'h0701});
    settle();

    // R8: eight-word loop, three passes
    for (int a = 16'h0200; a < 16'h0208; a++) begin
      do_fetch(16'(a), d, h, lat);
      check(d == {~16'(a), 16'(a)}, "R8", "first pass data", d, {~16'(a), 16'(a)});
    end
    settle();
    rd0 = rd_cnt;
    for (int p = 0; p < 2; p++) begin
      for (int a = 16'h0200; a < 16'h0208; a++) begin
        do_fetch(16'(a), d, h, lat);
        check(h == 1'b1, "R8", "loop hit", 32'(h), 1);
        check(d == {~16'(a), 16'(a)}, "R8", "loop data", d, {~16'(a), 16'(a)});
      end
    end
    settle();
    check(rd_cnt == rd0, "R8", "loop memory reads", 32'(rd_cnt - rd0), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule